// File: doc/BRIEF.md
# ATA Task-File Command Sequencer

This block is the device side of a parallel-ATA style register interface. A host reaches it through a 3-bit register offset, a read strobe and a write strobe. Bytes go in on a write bus, and a 16-bit read bus comes back. Offset 0 is the data port, offsets 2 to 6 are the task-file registers and offset 7 is both the status register (read) and the command register (write). The block decodes four commands: an identify page transfer, DMA read, DMA write and cache flush. It drives the status byte and an interrupt line that a status read acknowledges.

For the two DMA commands the sequencer sends a one-cycle request to an external DMA engine. The request carries a direction flag, the sector count and a 24-bit LBA built from the three LBA registers. The sequencer then stays busy until a done pulse returns. A flush sends a one-cycle request to the media side and stays busy until a media-done pulse arrives. The identify command streams a 256-word page one word per data-port read. The page is computed from a serial string and a revision string given as parameters, plus a write-cache-enabled flag.

Top module: `ata_taskfile_seq`

## Requirements
- R1: After reset, status (offset 7) reads 0x40 (DRDY) and irq, dma_req and flush_req are low.
- R2: Offsets 2 (count), 3, 4 and 5 (LBA bits 7:0, 15:8, 23:16) and 6 (device) read back the written byte in bits 7:0 with bits 15:8 zero. dma_lba is {off5, off4, off3}. dma_count equals the count register, and a count of 0 gives 256. A device value of 0x40 reads back with bit 0x10 clear.
- R3: Command 0xEC, written to offset 7 while idle, raises irq. Status then reads 0x48 (DRDY|DRQ) before each of 256 data-port reads. After the last read, status reads 0x40.
- R4: Identify word k (read k+1 of the transfer) is built from the parameter strings, first character in the high byte. Words 10 to 19 hold the 20-character serial and words 23 to 26 hold the 8-character revision. Word 85 is 0x0020 (bit 5 = write cache on). All other words are 0.
- R5: Commands 0xC8 and 0xCA drive dma_req high for exactly one cycle after the command write. dma_to_host is 1 for 0xC8 and 0 for 0xCA. Status reads 0xC0 (BSY|DRDY) until dma_done.
- R6: A dma_done pulse while busy returns status to 0x40 and raises irq. The next status read still returns 0x40 and lowers irq.
- R7: Command 0xE7 pulses flush_req for one cycle. Status reads 0xC0, with DF, ERR and DRQ clear, for as long as media_done stays low. A media_done pulse gives status 0x40 and irq high.
- R8: Any other command code gives status 0x41 (DRDY|ERR) and irq high. The next accepted command clears ERR.
- R9: While status shows BSY, writes to offsets 2 to 6 are ignored. A command write is ignored whenever the sequencer is not idle.
- R10: A command written while device bit 0x10 (secondary device) is set is ignored: status and irq stay unchanged.
- R11: When a completion (dma_done or media_done) and a status read fall in the same cycle, the read returns 0xC0 and irq is high afterwards.
- R12: A data-port read outside an identify transfer returns 0 and changes no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 16 | Read data for host_addr |
| irq | output | 1 | Interrupt request to the host |
| dma_req | output | 1 | One-cycle DMA start request |
| dma_to_host | output | 1 | 1 = device-to-host transfer |
| dma_count | output | 9 | Sector count, 1 to 256 |
| dma_lba | output | 24 | Starting LBA |
| dma_done | input | 1 | DMA completion pulse |
| flush_req | output | 1 | One-cycle flush request to the media |
| media_done | input | 1 | Flush completion pulse |

## Verification
A status read and a completion pulse can land in the same cycle. The read acknowledges the interrupt, and the completion raises it. The bench provokes this by raising host_rd at offset 7 together with dma_done while a DMA is busy. It judges the result by three things: the returned byte must still be the busy value 0xC0, irq must be high on the next cycle, and the following status read must return 0x40 and only then drop irq.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_COUNT = 3'd2;
  localparam logic [2:0] OFS_LBA0  = 3'd3;
  localparam logic [2:0] OFS_LBA1  = 3'd4;
  localparam logic [2:0] OFS_LBA2  = 3'd5;
  localparam logic [2:0] OFS_DEV   = 3'd6;
  localparam logic [2:0] OFS_CMDST = 3'd7;

  localparam logic [7:0] SB_BUSY  = 8'h80;
  localparam logic [7:0] SB_READY = 8'h40;
  localparam logic [7:0] SB_FAULT = 8'h20;
  localparam logic [7:0] SB_XFER  = 8'h08;
  localparam logic [7:0] SB_FAIL  = 8'h01;

  localparam logic [7:0] DEVB_SECOND = 8'h10;

  localparam logic [7:0] OP_DMA_IN  = 8'hC8;
  localparam logic [7:0] OP_DMA_OUT = 8'hCA;
  localparam logic [7:0] OP_FLUSH   = 8'hE7;
  localparam logic [7:0] OP_IDENT   = 8'hEC;

  typedef enum logic [1:0] {PH_IDLE, PH_XFER, PH_DMA, PH_FLUSH} phase_t;
endpackage

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs #(
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               busy,
  output logic [REG_W-1:0]   count_q,
  output logic [3*REG_W-1:0] lba_q,
  output logic [REG_W-1:0]   dev_q
);
  import ata_seq_pkg::*;

  logic [REG_W-1:0] count_d, dev_d;
  logic [REG_W-1:0] lba0_q, lba1_q, lba2_q, lba0_d, lba1_d, lba2_d;
  logic             wr_ok;

  assign wr_ok = wr_en && !busy;

  always_comb begin
    count_d = count_q;
    lba0_d  = lba0_q;
    lba1_d  = lba1_q;
    lba2_d  = lba2_q;
    dev_d   = dev_q;
    if (wr_ok) begin
      case (addr)
        OFS_COUNT: count_d = wdata;
        OFS_LBA0:  lba0_d  = wdata;
        OFS_LBA1:  lba1_d  = wdata;
        OFS_LBA2:  lba2_d  = wdata;
        OFS_DEV:   dev_d   = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      lba0_q  <= '0;
      lba1_q  <= '0;
      lba2_q  <= '0;
      dev_q   <= '0;
    end else begin
      count_q <= count_d;
      lba0_q  <= lba0_d;
      lba1_q  <= lba1_d;
      lba2_q  <= lba2_d;
      dev_q   <= dev_d;
    end
  end

  assign lba_q = {lba2_q, lba1_q, lba0_q};

  // R9
  tf_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable({count_q, lba_q, dev_q}));
endmodule

// File: rtl/ata_ident_rom.sv
module ata_ident_rom #(
  parameter int SER_CHARS = 20,
  parameter int REV_CHARS = 8,
  parameter logic [SER_CHARS*8-1:0] SERIAL = "testdisk            ",
  parameter logic [REV_CHARS*8-1:0] REV    = "version ",
  parameter int SER_BASE  = 10,
  parameter int REV_BASE  = 23,
  parameter int FEAT_WORD = 85,
  parameter int IDX_W     = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      word
);
  localparam int SER_WORDS = SER_CHARS / 2;
  localparam int REV_WORDS = REV_CHARS / 2;
  localparam int SER_TOP   = SER_CHARS * 8 - 1;
  localparam int REV_TOP   = REV_CHARS * 8 - 1;
  localparam logic [15:0] FEAT_VAL = 16'h0020;

  always_comb begin
    word = '0;
    for (int k = 0; k < SER_WORDS; k++) begin
      if (idx == IDX_W'(SER_BASE + k)) word = SERIAL[SER_TOP - 16*k -: 16];
    end
    for (int k = 0; k < REV_WORDS; k++) begin
      if (idx == IDX_W'(REV_BASE + k)) word = REV[REV_TOP - 16*k -: 16];
    end
    if (idx == IDX_W'(FEAT_WORD)) word = FEAT_VAL;
  end
endmodule

// File: rtl/ata_cmd_fsm.sv
module ata_cmd_fsm #(
  parameter int WORDS = 256,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  logic [7:0]           cmd_code,
  input  logic                 dev_second,
  input  logic                 data_rd,
  input  logic                 status_rd,
  input  logic                 dma_done,
  input  logic                 media_done,
  output ata_seq_pkg::phase_t  ph_q,
  output logic [IDX_W-1:0]     idx_q,
  output logic [7:0]           status,
  output logic                 irq_q,
  output logic                 dreq_q,
  output logic                 ddir_q,
  output logic                 freq_q
);
  import ata_seq_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  phase_t           ph_d;
  logic [IDX_W-1:0] idx_d;
  logic             err_q, err_d, irq_d, dreq_d, ddir_d, freq_d;

  always_comb begin
    ph_d   = ph_q;
    idx_d  = idx_q;
    err_d  = err_q;
    irq_d  = irq_q;
    dreq_d = 1'b0;
    ddir_d = ddir_q;
    freq_d = 1'b0;
    if (status_rd) irq_d = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (cmd_wr && !dev_second) begin
          err_d = 1'b0;
          case (cmd_code)
            OP_IDENT: begin
              ph_d  = PH_XFER;
              idx_d = '0;
              irq_d = 1'b1;
            end
            OP_DMA_IN, OP_DMA_OUT: begin
              ph_d   = PH_DMA;
              dreq_d = 1'b1;
              ddir_d = (cmd_code == OP_DMA_IN);
            end
            OP_FLUSH: begin
              ph_d   = PH_FLUSH;
              freq_d = 1'b1;
            end
            default: begin
              err_d = 1'b1;
              irq_d = 1'b1;
            end
          endcase
        end
      end
      PH_XFER: begin
        if (data_rd) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == LAST_IDX) ph_d = PH_IDLE;
        end
      end
      PH_DMA: begin
        if (dma_done) begin
          ph_d  = PH_IDLE;
          irq_d = 1'b1;
        end
      end
      PH_FLUSH: begin
        if (media_done) begin
          ph_d  = PH_IDLE;
          irq_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      dreq_q <= 1'b0;
      ddir_q <= 1'b0;
      freq_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      err_q  <= err_d;
      irq_q  <= irq_d;
      dreq_q <= dreq_d;
      ddir_q <= ddir_d;
      freq_q <= freq_d;
    end
  end

  always_comb begin
    case (ph_q)
      PH_XFER:  status = SB_READY | SB_XFER;
      PH_DMA,
      PH_FLUSH: status = SB_BUSY | SB_READY;
      default:  status = SB_READY | (err_q ? SB_FAIL : 8'h00);
    endcase
  end

  // R5
  dma_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_q |=> !dreq_q);
  // R7
  flush_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_q |=> !freq_q);
  // R11
  done_wins_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_DMA) && dma_done) |=> irq_q);
  // R5
  dma_holds_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_DMA) && !dma_done) |=> (ph_q == PH_DMA));
  // R3
  xfer_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_XFER) && data_rd && (idx_q == LAST_IDX)) |=> (ph_q == PH_IDLE));
  // R6
  ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && (ph_q == PH_XFER)) |=> !irq_q);
endmodule

// File: rtl/ata_taskfile_seq.sv
module ata_taskfile_seq #(
  parameter int REG_W     = 8,
  parameter int DATA_W    = 16,
  parameter int WORDS     = 256,
  parameter int SER_CHARS = 20,
  parameter int REV_CHARS = 8,
  parameter logic [SER_CHARS*8-1:0] SERIAL = "testdisk            ",
  parameter logic [REV_CHARS*8-1:0] REV    = "version "
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              dma_req,
  output logic              dma_to_host,
  output logic [REG_W:0]    dma_count,
  output logic [3*REG_W-1:0] dma_lba,
  input  logic              dma_done,
  output logic              flush_req,
  input  logic              media_done
);
  import ata_seq_pkg::*;

  localparam int IDX_W = $clog2(WORDS);
  localparam int PAD_W = DATA_W - REG_W;

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  phase_t             ph;
  logic [IDX_W-1:0]   idx;
  logic [7:0]         status;
  logic [REG_W-1:0]   count_q, dev_q;
  logic [3*REG_W-1:0] lba_q;
  logic [15:0]        id_word;
  logic               busy, cmd_wr, data_rd, status_rd;

  assign busy      = (ph == PH_DMA) || (ph == PH_FLUSH);
  assign cmd_wr    = host_wr && (host_addr == OFS_CMDST);
  assign data_rd   = host_rd && (host_addr == OFS_DATA);
  assign status_rd = host_rd && (host_addr == OFS_CMDST);

  ata_taskfile_regs #(.REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (host_wr),
    .addr    (host_addr),
    .wdata   (host_wdata),
    .busy    (busy),
    .count_q (count_q),
    .lba_q   (lba_q),
    .dev_q   (dev_q)
  );

  ata_cmd_fsm #(.WORDS(WORDS), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_s),
    .cmd_wr     (cmd_wr),
    .cmd_code   (8'(host_wdata)),
    .dev_second (|(8'(dev_q) & DEVB_SECOND)),
    .data_rd    (data_rd),
    .status_rd  (status_rd),
    .dma_done   (dma_done),
    .media_done (media_done),
    .ph_q       (ph),
    .idx_q      (idx),
    .status     (status),
    .irq_q      (irq),
    .dreq_q     (dma_req),
    .ddir_q     (dma_to_host),
    .freq_q     (flush_req)
  );

  ata_ident_rom #(
    .SER_CHARS (SER_CHARS),
    .REV_CHARS (REV_CHARS),
    .SERIAL    (SERIAL),
    .REV       (REV),
    .IDX_W     (IDX_W)
  ) u_rom (
    .idx  (idx),
    .word (id_word)
  );

  always_comb begin
    case (host_addr)
      OFS_DATA:  host_rdata = (ph == PH_XFER) ? DATA_W'(id_word) : '0;
      OFS_COUNT: host_rdata = {{PAD_W{1'b0}}, count_q};
      OFS_LBA0:  host_rdata = {{PAD_W{1'b0}}, lba_q[REG_W-1:0]};
      OFS_LBA1:  host_rdata = {{PAD_W{1'b0}}, lba_q[2*REG_W-1:REG_W]};
      OFS_LBA2:  host_rdata = {{PAD_W{1'b0}}, lba_q[3*REG_W-1:2*REG_W]};
      OFS_DEV:   host_rdata = {{PAD_W{1'b0}}, dev_q};
      OFS_CMDST: host_rdata = DATA_W'(status);
      default:   host_rdata = '0;
    endcase
  end

  assign dma_count = (count_q == '0) ? (REG_W+1)'(1 << REG_W) : {1'b0, count_q};
  assign dma_lba   = lba_q;

  // R12
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ((ph == PH_IDLE) && (host_addr == OFS_DATA)) |-> (host_rdata == '0));
endmodule

// File: tb/ata_taskfile_seq_test.sv
module ata_taskfile_seq_test;
  localparam logic [159:0] BSER = "testdisk            ";
  localparam logic [63:0]  BREV = "version ";

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq, dma_req, dma_to_host, flush_req;
  logic [8:0]  dma_count;
  logic [23:0] dma_lba;
  logic        dma_done = 1'b0, media_done = 1'b0;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ata_taskfile_seq #(.SERIAL(BSER), .REV(BREV)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .dma_req(dma_req), .dma_to_host(dma_to_host),
    .dma_count(dma_count), .dma_lba(dma_lba), .dma_done(dma_done),
    .flush_req(flush_req), .media_done(media_done)
  );

  // vector: {dev, cmd, status after command, irq after command, final status}
  localparam int NV = 8;
  localparam logic [32:0] VEC [NV] = '{
    {8'h00, 8'hEC, 8'h48, 1'b1, 8'h40},
    {8'h00, 8'hC8, 8'hC0, 1'b0, 8'h40},
    {8'h00, 8'hCA, 8'hC0, 1'b0, 8'h40},
    {8'h00, 8'hE7, 8'hC0, 1'b0, 8'h40},
    {8'h10, 8'hC8, 8'h40, 1'b0, 8'h40},
    {8'h40, 8'h55, 8'h41, 1'b1, 8'h41},
    {8'h40, 8'hEC, 8'h48, 1'b1, 8'h40},
    {8'h00, 8'h00, 8'h41, 1'b1, 8'h41}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic pulse_dma;
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
  endtask

  task automatic pulse_media;
    @(negedge clk); media_done = 1'b1;
    @(negedge clk); media_done = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(input int k);
    if (k >= 10 && k < 20) return BSER[159 - 16*(k-10) -: 16];
    if (k >= 23 && k < 27) return BREV[63 - 16*(k-23) -: 16];
    if (k == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  task automatic drain_ident(input bit judge);
    logic [15:0] s, w;
    int bad_s = 0, bad_w = 0;
    for (int i = 0; i < 256; i++) begin
      bus_rd(3'd7, s);
      if (s !== 16'h0048) bad_s++;
      bus_rd(3'd0, w);
      if (w !== exp_word(i)) begin
        bad_w++;
        if (judge) $display("word %0d got 0x%0h want 0x%0h", i, w, exp_word(i));
      end
    end
    if (judge) begin
      check("R3 status 0x48 before each word (bad count)", bad_s, 0);
      check("R4 identify page content (bad count)", bad_w, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(3'd7, r);
    check("R1 status after reset", r, 16'h0040);
    check("R1 irq/dma_req/flush_req after reset", {irq, dma_req, flush_req}, 3'b000);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0] vdev, vcmd, vst, vfin;
      logic       virq;
      {vdev, vcmd, vst, virq, vfin} = VEC[v];
      bus_rd(3'd7, r);
      bus_wr(3'd6, vdev);
      bus_wr(3'd7, vcmd);
      check($sformatf("R3/R5/R7/R8/R10 vector %0d irq", v), irq, virq);
      bus_rd(3'd7, r);
      check($sformatf("R3/R5/R7/R8/R10 vector %0d status", v), r, vst);
      if (vst == 8'h48) drain_ident(1'b0);
      else if (vst == 8'hC0 && vcmd == 8'hE7) pulse_media;
      else if (vst == 8'hC0) pulse_dma;
      bus_rd(3'd7, r);
      check($sformatf("R6/R8 vector %0d final status", v), r, vfin);
    end

    // R2 register readback and count/LBA assembly
    bus_wr(3'd6, 8'h40);
    bus_wr(3'd2, 8'h00);
    bus_wr(3'd3, 8'h56);
    bus_wr(3'd4, 8'h34);
    bus_wr(3'd5, 8'h12);
    bus_rd(3'd6, r);
    check("R2 device readback (secondary bit clear)", r, 16'h0040);
    bus_rd(3'd4, r);
    check("R2 LBA mid readback", r, 16'h0034);
    check("R2 dma_lba assembly", dma_lba, 24'h123456);
    check("R2 count 0 maps to 256", dma_count, 9'd256);

    // R5 read DMA
    bus_wr(3'd7, 8'hC8);
    check("R5 dma_req pulse and direction", {dma_req, dma_to_host}, 2'b11);
    @(negedge clk);
    check("R5 dma_req drops after one cycle", dma_req, 1'b0);
    // R9 writes ignored while busy
    bus_wr(3'd2, 8'h09);
    bus_rd(3'd2, r);
    check("R9 count write ignored while busy", r, 16'h0000);
    bus_wr(3'd7, 8'hEC);
    bus_rd(3'd7, r);
    check("R9 command ignored while busy", r, 16'h00C0);
    // R11 completion and status read in one cycle
    @(negedge clk);
    host_addr = 3'd7; host_rd = 1'b1; dma_done = 1'b1;
    #1 r = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; dma_done = 1'b0;
    check("R11 status read during completion", r, 16'h00C0);
    check("R11 irq survives simultaneous read", irq, 1'b1);
    bus_rd(3'd7, r);
    check("R6 status after DMA done", r, 16'h0040);
    check("R6 status read clears irq", irq, 1'b0);

    // R5 write DMA direction and count
    bus_wr(3'd2, 8'h05);
    bus_wr(3'd7, 8'hCA);
    check("R5 write DMA pulse, direction 0", {dma_req, dma_to_host}, 2'b10);
    check("R5 count 5", dma_count, 9'd5);
    pulse_dma;
    check("R6 irq after DMA done", irq, 1'b1);
    bus_rd(3'd7, r);

    // R7 flush holds busy
    bus_wr(3'd7, 8'hE7);
    check("R7 flush_req pulse", flush_req, 1'b1);
    repeat (10) @(negedge clk);
    bus_rd(3'd7, r);
    check("R7 busy while flush pending", r, 16'h00C0);
    pulse_media;
    check("R7 irq at flush done", irq, 1'b1);
    bus_rd(3'd7, r);
    check("R7 status after flush", r, 16'h0040);

    // R12 data read while idle
    bus_rd(3'd0, r);
    check("R12 idle data read returns 0", r, 16'h0000);
    bus_rd(3'd7, r);
    check("R12 idle data read leaves status", r, 16'h0040);

    // R8 unknown then valid clears ERR
    bus_wr(3'd7, 8'hA1);
    bus_rd(3'd7, r);
    check("R8 unknown command status", r, 16'h0041);
    // R3 R4 full identify with content
    bus_wr(3'd7, 8'hEC);
    check("R3 irq on identify", irq, 1'b1);
    drain_ident(1'b1);
    bus_rd(3'd7, r);
    check("R3/R8 status after last word, ERR cleared", r, 16'h0040);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule